// File: doc/BRIEF.md
# Register-Mapped Serial Port with Character Queues

A byte-oriented asynchronous serial port that a processor reaches through four word-sized registers on a 32-bit register bus. Characters written to the transmit register enter a 16-entry queue. A serializer sends each one as a low start bit, eight data bits least significant first, an optional fixed parity bit and a high stop bit. A deserializer that oversamples the input line 16 times per bit places received characters into a second 16-entry queue. Software drains that queue by reading the receive register.

The status register shows the fill state of both queues, the interrupt enable, and three error conditions. Overrun and framing errors are standalone events that can be present while no character is waiting. The parity error belongs to the character at the head of the receive queue. The control register flushes either queue and stores the interrupt enable. The flush bits take effect once and are not kept. A single interrupt line pulses for one clock when enabled and there is new work: a character has become available, or the transmit queue has just drained.

The bit period is `16*CLK_DIV` clock cycles, set by a parameter. Parity checking and generation are also selected by parameters. Bus accesses complete in a single cycle, and read data is valid during the cycle in which the read is presented. Bus byte order is little-endian.

Top module: `fifo_uart_port`

## Requirements
- R1: The word selected by address bits [3:2] decides the access. A read of 0 pops the receive data, with bits [31:8] zero. A write to 1 enqueues bits [7:0] for transmission. A read of 2 returns status. A write to 3 updates control. Reads of words 1 and 3 return 0, and writes to words 0 and 2 change nothing.
- R2: Status bits are: 0 receive data waiting, 1 receive queue full, 2 transmit queue empty, 3 transmit queue full, 4 interrupt enabled, 5 overrun, 6 framing error, 7 head character has a parity error. After reset the status reads 0x04, the line is high and the interrupt is low.
- R3: Each queue holds DEPTH (16) characters. A transmit write made while the queue is full is discarded.
- R4: The transmit line idles high. Each frame is a 0 start bit, eight data bits LSB first, an even parity bit (the XOR of the data when PARITY_EN=1, PARITY_ODD=0) and a 1 stop bit. Each bit lasts 16*CLK_DIV cycles.
- R5: The receiver recovers every 8-bit value sent in that frame format and queues the values in arrival order.
- R6: A character that completes while the receive queue is full is discarded and sets status bit 5. The queued characters are unchanged.
- R7: A frame whose stop bit is sampled low sets status bit 6 and is not queued. After such a frame the receiver waits for the line to return high before it looks for a new start bit.
- R8: A character with wrong parity is still queued. Status bit 7 is set while that character is at the head of the queue.
- R9: A status read clears bits 5 and 6. A receive flush also clears them.
- R10: Control bit 0 empties the transmit queue and control bit 1 empties the receive queue. Neither bit is stored, so later transmit writes are accepted normally. A frame already being shifted out completes.
- R11: Control bit 4 sets the interrupt enable, which reads back in status bit 4. A control write with bit 4 clear disables interrupts.
- R12: While enabled, the interrupt pulses for one cycle when the receive queue turns non-empty or the transmit queue turns empty. While disabled, it stays low.
- R13: A read of the receive register while the receive queue is empty returns 0 and leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address within the 16-byte region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is presented |
| irq | output | 1 | One-cycle interrupt pulse |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |

## Verification
The main sweep loops the transmit line back to the receive line and sends all 256 byte values in bursts of 16. Each value is decoded on the wire and read back from the receive queue, which separates bit-order, parity and timing errors in the serializer from sampling errors in the deserializer. Separate frames driven by the bench carry a corrupted parity bit, a low stop bit, or a seventeenth character into a full queue, so each error flag is exercised alone and its clear conditions can be told apart. Bursts of 18 writes and a flush issued mid-burst show how the transmit queue drops and discards characters, and interrupt pulses are counted with the enable set and clear.

// File: rtl/fup_pkg.sv
package fup_pkg;

    localparam int BUS_W  = 32;
    localparam int REG_AW = 4;
    localparam int OVS    = 16;   // oversampling ticks per bit

    // word index taken from address bits [3:2]
    typedef enum logic [1:0] {
        REG_RXD  = 2'd0,
        REG_TXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    localparam int CT_TXRST = 0;
    localparam int CT_RXRST = 1;
    localparam int CT_IE    = 4;

    // status byte, MSB first
    typedef struct packed {
        logic par;
        logic frm;
        logic ovr;
        logic ie;
        logic txf;
        logic txe;
        logic rxf;
        logic rxv;
    } stat_t;

    typedef struct packed {
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    function automatic logic par_bit(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/fup_fifo.sv
module fup_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> (full && $stable(rdata)));

    // R13
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/fup_tx.sv
module fup_tx import fup_pkg::*; #(
    parameter int CLK_DIV    = 4,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       avail,
    input  logic [7:0] data,
    output logic       take,
    output logic       txd
);
    localparam int BIT_CLKS = OVS * CLK_DIV;
    localparam int NBITS    = 10 + ((PARITY_EN != 0) ? 1 : 0);
    localparam int CCW      = $clog2(BIT_CLKS);
    localparam int BCW      = $clog2(NBITS + 1);

    logic             busy;
    logic [NBITS-1:0] sh, frame;
    logic [CCW-1:0]   ccnt;
    logic [BCW-1:0]   left;

    generate
        if (PARITY_EN != 0) begin : g_par
            assign frame = {1'b1, par_bit(data, 1'(PARITY_ODD)), data, 1'b0};
        end else begin : g_nopar
            assign frame = {1'b1, data, 1'b0};
        end
    endgenerate

    assign take = !busy && avail;
    assign txd  = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            ccnt <= '0;
            left <= '0;
        end else if (take) begin
            busy <= 1'b1;
            sh   <= frame;
            ccnt <= '0;
            left <= BCW'(NBITS);
        end else if (busy) begin
            if (ccnt == CCW'(BIT_CLKS - 1)) begin
                ccnt <= '0;
                sh   <= {1'b1, sh[NBITS-1:1]};
                left <= left - 1'b1;
                if (left == BCW'(1)) busy <= 1'b0;
            end else begin
                ccnt <= ccnt + 1'b1;
            end
        end
    end

    // R4
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);

endmodule

// File: rtl/fup_rx.sv
module fup_rx import fup_pkg::*; #(
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    output logic     out_valid,
    output rx_char_t out_char,
    output logic     out_ferr
);
    localparam logic [3:0] MID  = 4'(OVS / 2 - 1);
    localparam logic [3:0] LAST = 4'(OVS - 1);

    logic       s1, s2, prev, pbad;
    rx_state_e  st;
    logic [3:0] cnt;
    logic [2:0] bitn;
    logic [7:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1        <= 1'b1;
            s2        <= 1'b1;
            prev      <= 1'b1;
            st        <= RX_IDLE;
            cnt       <= '0;
            bitn      <= '0;
            sh        <= '0;
            pbad      <= 1'b0;
            out_valid <= 1'b0;
            out_ferr  <= 1'b0;
            out_char  <= '0;
        end else begin
            s1        <= rxd;
            s2        <= s1;
            out_valid <= 1'b0;
            out_ferr  <= 1'b0;
            if (tick) begin
                prev <= s2;
                case (st)
                    RX_IDLE: begin
                        // a start needs a high-to-low change on the line
                        if (prev && !s2) begin
                            st   <= RX_START;
                            cnt  <= '0;
                            pbad <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            cnt  <= '0;
                            bitn <= '0;
                            st   <= s2 ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            sh   <= {s2, sh[7:1]};
                            bitn <= bitn + 1'b1;
                            if (bitn == 3'd7) st <= (PARITY_EN != 0) ? RX_PAR : RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            pbad <= ((^sh) ^ s2) != 1'(PARITY_ODD);
                            st   <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST) begin
                            cnt <= '0;
                            st  <= RX_IDLE;
                            if (s2) begin
                                out_valid <= 1'b1;
                                out_char  <= '{perr: pbad, data: sh};
                            end else begin
                                out_ferr <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    // R7
    ferr_no_push_chk: assert property (@(posedge clk) disable iff (rst)
        out_ferr |-> !out_valid);

endmodule

// File: rtl/fifo_uart_port.sv
module fifo_uart_port import fup_pkg::*; #(
    parameter int DEPTH      = 16,
    parameter int CLK_DIV    = 4,
    parameter int PARITY_EN  = 1,
    parameter int PARITY_ODD = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    input  logic              ser_rx,
    output logic              ser_tx
);
    localparam int RXW = $bits(rx_char_t);

    // oversampling tick
    logic tick;
    generate
        if (CLK_DIV > 1) begin : g_div
            localparam int DW = $clog2(CLK_DIV);
            logic [DW-1:0] dcnt;
            always_ff @(posedge clk) begin
                if (rst) dcnt <= '0;
                else     dcnt <= (dcnt == DW'(CLK_DIV - 1)) ? '0 : dcnt + 1'b1;
            end
            assign tick = (dcnt == DW'(CLK_DIV - 1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // register decode
    reg_sel_e word;
    logic     rd, wr, ctl_wr, tx_push, rx_pop, stat_rd, tx_flush, rx_flush;

    assign word     = reg_sel_e'(bus_addr[3:2]);
    assign rd       = bus_sel && !bus_wr;
    assign wr       = bus_sel && bus_wr;
    assign ctl_wr   = wr && (word == REG_CTRL);
    assign tx_push  = wr && (word == REG_TXD);
    assign rx_pop   = rd && (word == REG_RXD);
    assign stat_rd  = rd && (word == REG_STAT);
    assign tx_flush = ctl_wr && bus_wdata[CT_TXRST];
    assign rx_flush = ctl_wr && bus_wdata[CT_RXRST];

    logic unused_bits;
    assign unused_bits = ^{bus_wdata[BUS_W-1:8], bus_addr[1:0]};

    // transmit path
    logic [7:0] tx_head;
    logic       tx_empty, tx_full, tx_take;

    fup_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_flush),
        .push  (tx_push),
        .wdata (bus_wdata[7:0]),
        .pop   (tx_take),
        .rdata (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    fup_tx #(.CLK_DIV(CLK_DIV), .PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_ser (
        .clk   (clk),
        .rst   (rst),
        .avail (!tx_empty),
        .data  (tx_head),
        .take  (tx_take),
        .txd   (ser_tx)
    );

    // receive path
    rx_char_t rx_char, rx_head;
    logic     rx_valid, rx_ferr, rx_empty, rx_full;

    fup_rx #(.PARITY_EN(PARITY_EN), .PARITY_ODD(PARITY_ODD)) u_des (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .rxd       (ser_rx),
        .out_valid (rx_valid),
        .out_char  (rx_char),
        .out_ferr  (rx_ferr)
    );

    fup_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (rx_valid),
        .wdata (rx_char),
        .pop   (rx_pop),
        .rdata (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    // flags and interrupt
    logic ie_q, ovr_q, frm_q, rxv_q, txe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= 1'b0;
            ovr_q <= 1'b0;
            frm_q <= 1'b0;
            rxv_q <= 1'b0;
            txe_q <= 1'b1;
            irq   <= 1'b0;
        end else begin
            if (ctl_wr) ie_q <= bus_wdata[CT_IE];
            if (rx_flush) begin
                ovr_q <= 1'b0;
                frm_q <= 1'b0;
            end else begin
                if (rx_valid && rx_full) ovr_q <= 1'b1;
                else if (stat_rd)        ovr_q <= 1'b0;
                if (rx_ferr)             frm_q <= 1'b1;
                else if (stat_rd)        frm_q <= 1'b0;
            end
            rxv_q <= !rx_empty;
            txe_q <= tx_empty;
            irq   <= ie_q && ((!rx_empty && !rxv_q) || (tx_empty && !txe_q));
        end
    end

    // read mux
    stat_t st;
    assign st = '{par: (!rx_empty && rx_head.perr), frm: frm_q, ovr: ovr_q, ie: ie_q,
                  txf: tx_full, txe: tx_empty, rxf: rx_full, rxv: !rx_empty};

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            case (word)
                REG_RXD:  if (!rx_empty) bus_rdata[7:0] = rx_head.data;
                REG_STAT: bus_rdata[7:0] = st;
                default:  ;
            endcase
        end
    end

    // R10
    tx_flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> tx_empty);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(ie_q));

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full && !rx_flush) |=> ovr_q);

    // R13
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_empty) |-> (bus_rdata == '0));

endmodule

// File: tb/fifo_uart_port_tb.sv
`timescale 1ns/1ps
module fifo_uart_port_tb;

    localparam int CDIV = 2;
    localparam int BITC = 16 * CDIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq, ser_tx, rx_line;
    logic        drv_rx = 1'b1, loop = 1'b0;

    int n_chk = 0, n_bad = 0, irq_cnt = 0, cap_n = 0;
    logic [7:0] cap [512];
    logic [7:0] mb;
    logic       mp, ms;

    always #10 clk = ~clk;   // 50 MHz

    assign rx_line = loop ? ser_tx : drv_rx;

    fifo_uart_port #(.DEPTH(16), .CLK_DIV(CDIV), .PARITY_EN(1), .PARITY_ODD(0)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .ser_rx(rx_line), .ser_tx(ser_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic bus_w(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_r(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic bad_par, input logic bad_stop);
        drv_rx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            drv_rx = b[i];
            repeat (BITC) @(negedge clk);
        end
        drv_rx = (^b) ^ bad_par;
        repeat (BITC) @(negedge clk);
        drv_rx = !bad_stop;
        repeat (BITC) @(negedge clk);
        drv_rx = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_stat(input int bitn, input logic val);
        logic [31:0] d;
        for (int g = 0; g < 30000; g++) begin
            bus_r(4'h8, d);
            if (d[bitn] == val) break;
        end
    endtask

    // interrupt pulse counter
    always @(negedge clk) if (irq === 1'b1) irq_cnt++;

    // transmit line decoder (R4)
    initial begin
        forever begin
            @(negedge clk);
            if (ser_tx === 1'b0) begin
                repeat (BITC / 2) @(negedge clk);
                check("R4 start", {31'b0, ser_tx}, 32'h0);
                for (int i = 0; i < 8; i++) begin
                    repeat (BITC) @(negedge clk);
                    mb[i] = ser_tx;
                end
                repeat (BITC) @(negedge clk);
                mp = ser_tx;
                repeat (BITC) @(negedge clk);
                ms = ser_tx;
                check("R4 parity", {31'b0, mp}, {31'b0, ^mb});
                check("R4 stop", {31'b0, ms}, 32'h1);
                cap[cap_n] = mb;
                cap_n++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog act=running exp=finished");
        finish_up();
    end

    initial begin
        logic [31:0] d;
        int n0, i0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        bus_r(4'h8, d);      check("R2 status", d, 32'h04);
        check("R2 line", {31'b0, ser_tx}, 32'h1);
        check("R2 irq", {31'b0, irq}, 32'h0);

        // R1 unused reads and writes
        bus_r(4'h4, d);      check("R1 txd read", d, 32'h0);
        bus_r(4'hC, d);      check("R1 ctrl read", d, 32'h0);
        bus_w(4'h0, 32'hFF);
        bus_w(4'h8, 32'hFF);
        bus_r(4'h8, d);      check("R1 status unchanged", d, 32'h04);

        // R13 empty read
        bus_r(4'h0, d);      check("R13 empty data", d, 32'h0);
        bus_r(4'h8, d);      check("R13 still empty", d, 32'h04);

        // R11 enable readback
        bus_w(4'hC, 32'h10);
        bus_r(4'h8, d);      check("R11 ie set", d, 32'h14);
        bus_w(4'hC, 32'h00);
        bus_r(4'h8, d);      check("R11 ie clear", d, 32'h04);

        // R3 transmit queue depth and drop
        n0 = cap_n;
        for (int i = 0; i < 18; i++) bus_w(4'h4, 32'h10 + i);
        bus_r(4'h8, d);      check("R3 tx full", d, 32'h08);
        wait_stat(2, 1'b1);
        repeat (12 * BITC) @(negedge clk);
        check("R3 sent count", cap_n - n0, 17);
        for (int i = 0; i < 17; i++) check("R3 order", {24'b0, cap[n0 + i]}, 32'h10 + i);

        // R10 transmit flush during a burst, bit not stored
        n0 = cap_n;
        for (int i = 0; i < 5; i++) bus_w(4'h4, 32'hA0 + i);
        bus_w(4'hC, 32'h01);
        bus_r(4'h8, d);      check("R10 tx flushed", d, 32'h04);
        repeat (14 * BITC) @(negedge clk);
        check("R10 only shifter char", cap_n - n0, 1);
        check("R10 shifter value", {24'b0, cap[n0]}, 32'hA0);
        bus_w(4'h4, 32'h77);
        repeat (14 * BITC) @(negedge clk);
        check("R10 later write sent", cap_n - n0, 2);
        check("R10 later value", {24'b0, cap[n0 + 1]}, 32'h77);

        // R6 overrun with full receive queue
        for (int i = 0; i < 17; i++) send_frame(8'((i * 7 + 3) & 255), 1'b0, 1'b0);
        bus_r(4'h8, d);      check("R6 overrun status", d, 32'h27);
        bus_r(4'h8, d);      check("R9 read clears overrun", d, 32'h07);
        for (int i = 0; i < 16; i++) begin
            bus_r(4'h0, d);  check("R6 kept data", d, 32'((i * 7 + 3) & 255));
        end
        bus_r(4'h8, d);      check("R6 drained", d, 32'h04);

        // R7 framing error
        send_frame(8'h55, 1'b0, 1'b1);
        bus_r(4'h8, d);      check("R7 frame flag", d, 32'h44);
        bus_r(4'h8, d);      check("R9 read clears frame", d, 32'h04);
        send_frame(8'h3C, 1'b0, 1'b0);
        bus_r(4'h0, d);      check("R7 recovers", d, 32'h3C);

        // R9 receive flush clears flags; R10 receive flush
        send_frame(8'h55, 1'b0, 1'b1);
        send_frame(8'h11, 1'b0, 1'b0);
        bus_w(4'hC, 32'h02);
        bus_r(4'h8, d);      check("R10 R9 rx flush", d, 32'h04);

        // R8 parity error at the head
        send_frame(8'h5A, 1'b1, 1'b0);
        send_frame(8'h33, 1'b0, 1'b0);
        bus_r(4'h8, d);      check("R8 head parity", d, 32'h85);
        bus_r(4'h0, d);      check("R8 bad char kept", d, 32'h5A);
        bus_r(4'h8, d);      check("R8 next head clean", d, 32'h05);
        bus_r(4'h0, d);      check("R8 good char", d, 32'h33);

        // R12 interrupt pulses
        bus_w(4'hC, 32'h10);
        i0 = irq_cnt;
        send_frame(8'h41, 1'b0, 1'b0);
        check("R12 rx irq", irq_cnt - i0, 1);
        bus_r(4'h0, d);      check("R12 rx data", d, 32'h41);
        bus_w(4'h4, 32'h42);
        repeat (14 * BITC) @(negedge clk);
        check("R12 tx irq", irq_cnt - i0, 2);
        bus_w(4'hC, 32'h00);
        send_frame(8'h43, 1'b0, 1'b0);
        bus_r(4'h0, d);      check("R12 masked data", d, 32'h43);
        bus_w(4'h4, 32'h44);
        repeat (14 * BITC) @(negedge clk);
        check("R12 masked", irq_cnt - i0, 2);

        // R5 loopback sweep over all byte values
        loop = 1'b1;
        n0 = cap_n;
        for (int blk = 0; blk < 16; blk++) begin
            for (int k = 0; k < 16; k++) bus_w(4'h4, 32'(blk * 16 + k));
            for (int k = 0; k < 16; k++) begin
                wait_stat(0, 1'b1);
                bus_r(4'h8, d);  check("R8 sweep parity", {31'b0, d[7]}, 32'h0);
                bus_r(4'h0, d);  check("R5 sweep data", d, 32'(blk * 16 + k));
            end
        end
        repeat (12 * BITC) @(negedge clk);
        check("R4 sweep count", cap_n - n0, 256);
        for (int v = 0; v < 256; v++) check("R4 sweep wire", {24'b0, cap[n0 + v]}, 32'(v));
        bus_r(4'h8, d);      check("R2 final status", d, 32'h04);

        finish_up();
    end

endmodule